// File: doc/BRIEF.md
# Conditioned Reset Output Generator

This block produces the device-wide reset. It drives an active-low reset pin, an active-high internal core reset and an active-high tri-state request for the parallel FIFO data and control pins. Release needs three conditions together: supply good, oscillator running and the external active-low reset input high. After all three hold, a timed hold-off must run out before the reset is lifted. With the default count on a 12 MHz clock, the hold-off is about 5 ms. Because the reset pin can switch the bus pull-up resistor, the same hold-off also delays enumeration.

Supply detection and the oscillator are outside this block. They arrive as digital level inputs. Any of the three conditions going low forces reset at once, without waiting for a clock edge. Release is clocked. The combined condition passes through a synchroniser and then through a hold counter. If the combined condition drops at any point before release, the counter goes back to zero. A USB bus reset indication is an input, but it never affects the outputs.

Top module: `cond_reset_gen`

## Requirements
- R1: While any of `pwr_ok`, `osc_run`, `ext_rst_n` is low, `rst_out_n` is 0, `core_rst` is 1 and `fifo_hiz` is 1.
- R2: When all three conditions go high before a rising clock edge and stay high, `rst_out_n` goes to 1 right after the (HOLD_CYCLES + SYNC_STAGES)-th rising edge counted from that edge. It is not 1 at any earlier point.
- R3: Driving `ext_rst_n` low forces `rst_out_n` low within the same clock phase, with no clock edge needed.
- R4: Driving `pwr_ok` or `osc_run` low forces `rst_out_n` low within the same clock phase, with no clock edge needed.
- R5: If any condition drops before release, the hold-off restarts from zero. A later release again needs the full HOLD_CYCLES + SYNC_STAGES edges of unbroken conditions.
- R6: `usb_bus_rst` has no effect on any output, before or after release.
- R7: `core_rst` and `fifo_hiz` are always the inverse of `rst_out_n`.
- R8: Once released, `rst_out_n` stays 1 for as long as all three conditions stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running 12 MHz clock from the oscillator multiplier |
| pwr_ok | input | 1 | Supply above threshold, active high |
| osc_run | input | 1 | Oscillator running, active high |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| usb_bus_rst | input | 1 | USB bus reset indication; deliberately ignored |
| rst_out_n | output | 1 | Reset output pin, active low |
| core_rst | output | 1 | Internal core reset, active high |
| fifo_hiz | output | 1 | Tri-state request for FIFO data and control pins, active high |

## Verification
Assertion is combinational. The bench therefore checks a falling condition a short delay after driving it, in the same half-cycle, with no clock edge in between. Release is due exactly HOLD_CYCLES + SYNC_STAGES rising edges after the conditions first hold. The bench model counts edges of unbroken conditions and compares the three outputs after every falling edge, one nanosecond after the inputs are driven. A separate check counts the cycles up to the first release and compares that count with the expected latency.

// File: rtl/crg_pkg.sv
package crg_pkg;

    typedef struct packed {
        logic rst_n;
        logic core_rst;
        logic fifo_hiz;
    } crg_out_t;

    function automatic int unsigned crg_cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic crg_out_t crg_drive(input logic live);
        crg_out_t o;
        o.rst_n    = live;
        o.core_rst = ~live;
        o.fifo_hiz = ~live;
        return o;
    endfunction

endpackage

// File: rtl/crg_sync.sv
module crg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) st[0] <= 1'b0;
                else        st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) st[i] <= 1'b0;
                else        st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/crg_hold_timer.sv
module crg_hold_timer
    import crg_pkg::*;
#(
    parameter int unsigned HOLD = 60000
) (
    input  logic clk,
    input  logic clr_n,
    input  logic arm,
    output logic done
);
    localparam int unsigned W = crg_cnt_w(HOLD);
    localparam logic [W-1:0] LAST = W'(HOLD - 1);

    logic [W-1:0] cnt_q;
    logic         done_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!arm) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done = done_q;

    // R2: release only after the full count
    a_r2_full_count: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(done_q) |-> $past(cnt_q) == LAST);

    // R8: release is sticky while armed
    a_r8_sticky: assert property (@(posedge clk) disable iff (!clr_n)
        (done_q && arm) |=> done_q);

    // R5: a lost condition cancels any progress
    a_r5_restart: assert property (@(posedge clk) disable iff (!clr_n)
        !arm |=> (!done_q && cnt_q == '0));
endmodule

// File: rtl/cond_reset_gen.sv
module cond_reset_gen
    import crg_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 60000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic osc_run,
    input  logic ext_rst_n,
    input  logic usb_bus_rst,
    output logic rst_out_n,
    output logic core_rst,
    output logic fifo_hiz
);
    logic     cond_raw;
    logic     cond_sync;
    logic     released;
    crg_out_t outs;

    assign cond_raw = pwr_ok & osc_run & ext_rst_n;

    crg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .clr_n(cond_raw),
        .d    (1'b1),
        .q    (cond_sync)
    );

    crg_hold_timer #(.HOLD(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .clr_n(cond_raw),
        .arm  (cond_sync),
        .done (released)
    );

    assign outs      = crg_drive(released & cond_raw);
    assign rst_out_n = outs.rst_n;
    assign core_rst  = outs.core_rst;
    assign fifo_hiz  = outs.fifo_hiz;

    // R1 / R3 / R4: a missing condition always holds reset
    always_comb begin
        if (!ext_rst_n || !pwr_ok || !osc_run)
            a_r1_cond_low_holds: assert (!rst_out_n && fifo_hiz);
    end

    // R6: bus reset never pulls the output down
    a_r6_bus_ignored: assert property (@(posedge clk) disable iff (!cond_raw)
        (released && usb_bus_rst) |-> rst_out_n);

    // R2: no release without a synchronised condition
    a_r2_needs_sync: assert property (@(posedge clk) disable iff (!cond_raw)
        rst_out_n |-> cond_sync);
endmodule

// File: tb/cond_reset_gen_test.sv
module cond_reset_gen_test;
    localparam int unsigned HOLD = 12;
    localparam int unsigned SYNC = 2;
    localparam int unsigned LAT  = HOLD + SYNC;

    logic clk = 1'b0;
    logic pwr_ok = 1'b0, osc_run = 1'b0, ext_rst_n = 1'b0, usb_bus_rst = 1'b0;
    logic rst_out_n, core_rst, fifo_hiz;

    int tests = 0;
    int fails = 0;
    int streak = 0;
    bit finished = 0;

    cond_reset_gen #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .pwr_ok(pwr_ok), .osc_run(osc_run), .ext_rst_n(ext_rst_n),
        .usb_bus_rst(usb_bus_rst), .rst_out_n(rst_out_n),
        .core_rst(core_rst), .fifo_hiz(fifo_hiz)
    );

    always #10 clk = ~clk;

    // reference: count rising edges with all conditions high
    always @(posedge clk) begin
        if (pwr_ok && osc_run && ext_rst_n) streak = streak + 1;
        else                                streak = 0;
    end

    task automatic check_now(input string tag);
        logic exp_n;
        #1;
        exp_n = (pwr_ok && osc_run && ext_rst_n && streak >= LAT);
        tests++;
        if (rst_out_n !== exp_n) begin
            fails++;
            $display("FAIL %s rst_out_n actual=%b expected=%b", tag, rst_out_n, exp_n);
        end
        tests++;
        if (core_rst !== ~exp_n || fifo_hiz !== ~exp_n) begin
            fails++;
            $display("FAIL R7 core_rst/fifo_hiz actual=%b%b expected=%b%b",
                     core_rst, fifo_hiz, ~exp_n, ~exp_n);
        end
    endtask

    task automatic step(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now(tag);
        end
    endtask

    task automatic all_high();
        @(negedge clk);
        pwr_ok = 1; osc_run = 1; ext_rst_n = 1;
        check_now("R1");
    endtask

    initial begin
        int k;
        // R1: reset state with conditions low
        step("R1", 4);
        @(negedge clk); pwr_ok = 1; check_now("R1");
        @(negedge clk); osc_run = 1; check_now("R1");
        step("R1", 3);

        // R2: exact release latency
        @(negedge clk); ext_rst_n = 1; check_now("R2");
        k = 0;
        for (int i = 1; i <= LAT + 4; i++) begin
            @(negedge clk);
            check_now("R2");
            if (k == 0 && rst_out_n === 1'b1) k = i;
        end
        tests++;
        if (k != LAT) begin
            fails++;
            $display("FAIL R2 release cycle actual=%0d expected=%0d", k, LAT);
        end

        // R6 / R8: bus reset pulses after release
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); usb_bus_rst = i[0]; check_now("R6");
        end
        usb_bus_rst = 0;
        step("R8", 5);

        // R3: immediate assertion from ext_rst_n, same half-cycle
        @(negedge clk); ext_rst_n = 0; check_now("R3");
        step("R3", 2);

        // R5: drop of pwr_ok during the hold-off
        @(negedge clk); ext_rst_n = 1; check_now("R5");
        step("R5", 6);
        @(negedge clk); pwr_ok = 0; check_now("R4");
        @(negedge clk); pwr_ok = 1; check_now("R5");
        step("R5", LAT + 3);

        // R4: osc_run drop after release, and bus reset during hold-off
        @(negedge clk); osc_run = 0; check_now("R4");
        @(negedge clk); osc_run = 1; usb_bus_rst = 1; check_now("R6");
        step("R6", 4);
        usb_bus_rst = 0;
        step("R5", LAT + 2);

        // R4: pwr_ok drop after release
        @(negedge clk); pwr_ok = 0; check_now("R4");
        step("R1", 2);
        all_high();
        step("R2", LAT + 2);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule